// File: doc/BRIEF.md
# Loop Replay Buffer

This block sits after the execute stage of a simple instruction pipeline. It keeps a circular record of the most recently executed instruction words, each stored with its fetch address. When an instruction tagged as a loop head goes past, the block notes where that word landed in the record and which address it came from. Several such loop heads are watched at the same time, so nested loops are covered.

A later branch whose target equals one of the watched loop heads is answered from the record, one word per cycle, with no access to program memory. Replay stops on its own when it reaches the newest stored word or finds a break in the address sequence. At that point the block raises a one-cycle miss request carrying the next address to fetch. A branch to an address that no valid loop head matches raises the same one-cycle miss request, carrying the branch target.

Top module: `loop_replay_buf`

## Requirements
- R1: After a synchronous reset (rst high at a rising edge), fe_valid and miss_req are both 0 until a branch is presented.
- R2: Each cycle with ex_valid high stores {ex_addr, ex_word} in the next position of a 32-entry circular record. When the record is full, the oldest word is the one replaced.
- R3: An executed word with ex_loop_start high registers a loop head (its record position and address). A later branch with br_target equal to that address replays the stored words in program order, starting with that word.
- R4: A replayed word appears on fe_valid/fe_addr/fe_word in the cycle right after the cycle in which the hitting branch is presented. Each further word follows one cycle later.
- R5: Up to 4 loop heads are valid at once, and a branch to any of them hits. Nested loop heads in one run of code can all be replayed.
- R6: A loop head becomes invalid in the cycle its record position is overwritten by a new executed word. A branch to it after that is a miss.
- R7: Replay ends when the next read position equals the write position (except for the first replayed word). In that cycle fe_valid is 0, miss_req is 1 and miss_addr is the last replayed address plus 1.
- R8: Replay ends when the next stored word's address is not the previous address plus 1. In that cycle fe_valid is 0, miss_req is 1 and miss_addr is the expected sequential address.
- R9: A new loop head whose address matches a valid head updates that head in place. Otherwise it takes a free head slot, or, when all 4 are valid, replaces slots in round-robin order starting from slot 0.
- R10: A branch that matches no valid loop head makes miss_req 1 with miss_addr equal to br_target for exactly the next cycle, and stops any replay in progress.
- R11: No word is replayed before the first loop head has been registered after reset.
- R12: A branch presented during a replay takes effect in the next cycle: a hit restarts the replay at the new head, and a miss follows R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ex_valid | input | 1 | An executed instruction is presented |
| ex_addr | input | 16 | Fetch address of the executed instruction |
| ex_word | input | 32 | Instruction word |
| ex_loop_start | input | 1 | The executed instruction is a loop head |
| br_valid | input | 1 | A branch is taken this cycle |
| br_target | input | 16 | Branch target address |
| fe_valid | output | 1 | A replayed word is presented |
| fe_addr | output | 16 | Address of the replayed word |
| fe_word | output | 32 | Replayed instruction word |
| miss_req | output | 1 | Fetch from program memory is required |
| miss_addr | output | 16 | Address program memory must supply |

## Verification
The assertions assume that at most one executed word and at most one branch arrive per cycle, and that a branch may land in any cycle, including during a replay or in the same cycle as a write. The stimulus respects this. It mixes straight-line runs, address jumps, repeated loop heads and writes that arrive during a replay. It also writes past the record's capacity, so that overwrite invalidation and round-robin slot reuse actually occur instead of staying at their empty-buffer states.

// File: rtl/lrb_pkg.sv
package lrb_pkg;

    localparam int ADDR_W = 16;
    localparam int WORD_W = 32;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        addr_t addr;
        word_t word;
    } rec_t;

    typedef enum logic [1:0] {
        RP_IDLE  = 2'd0,
        RP_PLAY  = 2'd1,
        RP_MISS  = 2'd2
    } rp_mode_e;

    function automatic addr_t addr_succ(input addr_t a);
        return a + addr_t'(1);
    endfunction

endpackage

// File: rtl/lrb_store.sv
module lrb_store
    import lrb_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  rec_t          wr_rec,
    input  logic [IW-1:0] rd_pos,
    output rec_t          rd_rec,
    output logic          rd_full,
    output logic [IW-1:0] wr_pos
);

    rec_t             mem [DEPTH];
    logic [DEPTH-1:0] held;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_pos <= '0;
            held   <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_pos]  <= wr_rec;
            held[wr_pos] <= 1'b1;
            wr_pos       <= (wr_pos == IW'(DEPTH - 1)) ? '0 : wr_pos + 1'b1;
        end
    end

    assign rd_rec  = mem[rd_pos];
    assign rd_full = held[rd_pos];

    // R2
    stored_held_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> held[$past(wr_pos)] && mem[$past(wr_pos)] == $past(wr_rec));

    // R2
    wp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(wr_pos));

endmodule

// File: rtl/lrb_heads.sv
module lrb_heads
    import lrb_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int NHEAD = 4,
    localparam int IW = $clog2(DEPTH),
    localparam int TW = (NHEAD > 1) ? $clog2(NHEAD) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          wr_head,
    input  addr_t         wr_addr,
    input  logic [IW-1:0] wr_pos,
    input  addr_t         q_addr,
    output logic          q_hit,
    output logic [IW-1:0] q_pos
);

    logic [NHEAD-1:0] live;
    logic [IW-1:0]    hpos  [NHEAD];
    addr_t            haddr [NHEAD];
    logic [TW-1:0]    rr;

    logic [NHEAD-1:0] keep;
    logic [NHEAD-1:0] same;
    logic [NHEAD-1:0] qmatch;
    logic [TW-1:0]    pick;
    logic             pick_rr;
    logic             found;

    generate
        for (genvar g = 0; g < NHEAD; g++) begin : g_cmp
            assign keep[g]   = live[g] && !(wr_en && hpos[g] == wr_pos);
            assign same[g]   = keep[g] && haddr[g] == wr_addr;
            assign qmatch[g] = live[g] && haddr[g] == q_addr;
        end
    endgenerate

    always_comb begin
        pick    = rr;
        pick_rr = 1'b1;
        found   = 1'b0;
        for (int i = 0; i < NHEAD; i++) begin
            if (!found && same[i]) begin
                pick = TW'(i); pick_rr = 1'b0; found = 1'b1;
            end
        end
        for (int i = 0; i < NHEAD; i++) begin
            if (!found && !keep[i]) begin
                pick = TW'(i); pick_rr = 1'b0; found = 1'b1;
            end
        end
    end

    always_comb begin
        q_hit = 1'b0;
        q_pos = '0;
        for (int i = 0; i < NHEAD; i++) begin
            if (qmatch[i]) begin
                q_hit = 1'b1;
                q_pos = hpos[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live <= '0;
            rr   <= '0;
            for (int i = 0; i < NHEAD; i++) begin
                hpos[i]  <= '0;
                haddr[i] <= '0;
            end
        end else if (wr_en) begin
            live <= keep;
            if (wr_head) begin
                live[pick]  <= 1'b1;
                hpos[pick]  <= wr_pos;
                haddr[pick] <= wr_addr;
                if (pick_rr) rr <= (rr == TW'(NHEAD - 1)) ? '0 : rr + 1'b1;
            end
        end
    end

    // R9
    head_unique_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(qmatch));

    generate
        for (genvar g = 0; g < NHEAD; g++) begin : g_chk
            // R6
            head_overwrite_chk: assert property (@(posedge clk) disable iff (rst)
                (wr_en && !wr_head) |=> !(live[g] && hpos[g] == $past(wr_pos)));
        end
    endgenerate

endmodule

// File: rtl/lrb_player.sv
module lrb_player
    import lrb_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          br_valid,
    input  addr_t         br_target,
    input  logic          head_hit,
    input  logic [IW-1:0] head_pos,
    input  rec_t          rd_rec,
    input  logic          rd_full,
    input  logic [IW-1:0] wr_pos,
    output logic [IW-1:0] rd_pos,
    output logic          fe_valid,
    output addr_t         fe_addr,
    output word_t         fe_word,
    output logic          miss_req,
    output addr_t         miss_addr
);

    rp_mode_e mode;
    addr_t    want;
    logic     first;
    addr_t    miss_q;
    logic     ok;

    assign ok = (mode == RP_PLAY) && rd_full && rd_rec.addr == want
                && (first || rd_pos != wr_pos);

    always_comb begin
        fe_valid  = ok;
        fe_addr   = rd_rec.addr;
        fe_word   = rd_rec.word;
        miss_req  = 1'b0;
        miss_addr = miss_q;
        if (mode == RP_PLAY && !ok) begin
            miss_req  = 1'b1;
            miss_addr = want;
        end else if (mode == RP_MISS) begin
            miss_req  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode   <= RP_IDLE;
            rd_pos <= '0;
            want   <= '0;
            first  <= 1'b0;
            miss_q <= '0;
        end else if (br_valid) begin
            if (head_hit) begin
                mode   <= RP_PLAY;
                rd_pos <= head_pos;
                want   <= br_target;
                first  <= 1'b1;
            end else begin
                mode   <= RP_MISS;
                miss_q <= br_target;
            end
        end else if (ok) begin
            rd_pos <= (rd_pos == IW'(DEPTH - 1)) ? '0 : rd_pos + 1'b1;
            want   <= addr_succ(want);
            first  <= 1'b0;
        end else begin
            mode <= RP_IDLE;
        end
    end

    // R10
    miss_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (miss_req && !br_valid) |=> !miss_req);

    // R7
    seq_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        (fe_valid && !br_valid) |=> (!fe_valid || fe_addr == addr_succ($past(fe_addr))));

    // R4
    hit_answer_chk: assert property (@(posedge clk) disable iff (rst)
        (br_valid && head_hit) |=> (fe_valid ^ miss_req));

    // R10
    miss_target_chk: assert property (@(posedge clk) disable iff (rst)
        (br_valid && !head_hit) |=> (miss_req && !fe_valid && miss_addr == $past(br_target)));

endmodule

// File: rtl/loop_replay_buf.sv
module loop_replay_buf
    import lrb_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int NHEAD = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ex_valid,
    input  logic [15:0] ex_addr,
    input  logic [31:0] ex_word,
    input  logic        ex_loop_start,
    input  logic        br_valid,
    input  logic [15:0] br_target,
    output logic        fe_valid,
    output logic [15:0] fe_addr,
    output logic [31:0] fe_word,
    output logic        miss_req,
    output logic [15:0] miss_addr
);

    localparam int IW = $clog2(DEPTH);

    rec_t          wr_rec;
    rec_t          rd_rec;
    logic          rd_full;
    logic [IW-1:0] wr_pos;
    logic [IW-1:0] rd_pos;
    logic          head_hit;
    logic [IW-1:0] head_pos;

    assign wr_rec = '{addr: ex_addr, word: ex_word};

    lrb_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst),
        .wr_en(ex_valid), .wr_rec(wr_rec),
        .rd_pos(rd_pos), .rd_rec(rd_rec), .rd_full(rd_full),
        .wr_pos(wr_pos)
    );

    lrb_heads #(.DEPTH(DEPTH), .NHEAD(NHEAD)) u_heads (
        .clk(clk), .rst(rst),
        .wr_en(ex_valid), .wr_head(ex_loop_start), .wr_addr(ex_addr),
        .wr_pos(wr_pos), .q_addr(br_target),
        .q_hit(head_hit), .q_pos(head_pos)
    );

    lrb_player #(.DEPTH(DEPTH)) u_player (
        .clk(clk), .rst(rst),
        .br_valid(br_valid), .br_target(br_target),
        .head_hit(head_hit), .head_pos(head_pos),
        .rd_rec(rd_rec), .rd_full(rd_full), .wr_pos(wr_pos),
        .rd_pos(rd_pos),
        .fe_valid(fe_valid), .fe_addr(fe_addr), .fe_word(fe_word),
        .miss_req(miss_req), .miss_addr(miss_addr)
    );

    logic seen_head;
    always_ff @(posedge clk) begin
        if (rst)                            seen_head <= 1'b0;
        else if (ex_valid && ex_loop_start) seen_head <= 1'b1;
    end

    // R11
    no_early_hit_chk: assert property (@(posedge clk) disable iff (rst)
        !seen_head |-> !fe_valid);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!fe_valid && !miss_req));

endmodule

// File: tb/sim_loop_replay_buf.sv
module sim_loop_replay_buf;

    localparam int DEPTH = 32;
    localparam int NHEAD = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ex_valid = 1'b0;
    logic [15:0] ex_addr = '0;
    logic [31:0] ex_word = '0;
    logic        ex_loop_start = 1'b0;
    logic        br_valid = 1'b0;
    logic [15:0] br_target = '0;
    logic        fe_valid;
    logic [15:0] fe_addr;
    logic [31:0] fe_word;
    logic        miss_req;
    logic [15:0] miss_addr;

    always #4 clk = ~clk;

    loop_replay_buf u0 (
        .clk(clk), .rst(rst),
        .ex_valid(ex_valid), .ex_addr(ex_addr), .ex_word(ex_word),
        .ex_loop_start(ex_loop_start),
        .br_valid(br_valid), .br_target(br_target),
        .fe_valid(fe_valid), .fe_addr(fe_addr), .fe_word(fe_word),
        .miss_req(miss_req), .miss_addr(miss_addr)
    );

    int total = 0;
    int bad = 0;
    string tag = "R1";

    // behavioural reference: record as parallel int arrays, heads as a list
    int  r_addr [DEPTH];
    int  r_word [DEPTH];
    bit  r_held [DEPTH];
    int  r_wp;
    bit  h_live [NHEAD];
    int  h_pos  [NHEAD];
    int  h_addr [NHEAD];
    int  h_rr;
    int  m_mode;          // 0 idle, 1 playing, 2 miss
    int  m_rp;
    int  m_want;
    bit  m_first;
    int  m_missq;
    int  hits_seen;       // replayed words observed

    function automatic void ref_reset();
        for (int i = 0; i < DEPTH; i++) begin
            r_addr[i] = 0; r_word[i] = 0; r_held[i] = 0;
        end
        for (int i = 0; i < NHEAD; i++) begin
            h_live[i] = 0; h_pos[i] = 0; h_addr[i] = 0;
        end
        r_wp = 0; h_rr = 0; m_mode = 0; m_rp = 0;
        m_want = 0; m_first = 0; m_missq = 0;
    endfunction

    function automatic bit ref_ok();
        return m_mode == 1 && r_held[m_rp] && r_addr[m_rp] == m_want
               && (m_first || m_rp != r_wp);
    endfunction

    function automatic void check(input string req, input string what,
                                  input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h at %0t", req, what, act, exp, $time);
        end
    endfunction

    task automatic compare();
        bit ok = ref_ok();
        int e_miss = (m_mode == 1 && !ok) || m_mode == 2;
        check(tag, "fe_valid", int'(fe_valid), int'(ok));
        check(tag, "miss_req", int'(miss_req), e_miss);
        if (ok) begin
            check(tag, "fe_addr", int'(fe_addr), r_addr[m_rp]);
            check(tag, "fe_word", int'(fe_word), r_word[m_rp]);
            hits_seen++;
        end
        if (m_mode == 1 && !ok) check(tag, "miss_addr", int'(miss_addr), m_want);
        if (m_mode == 2)        check(tag, "miss_addr", int'(miss_addr), m_missq);
    endtask

    function automatic void ref_step(input bit rs, input bit ev, input int ea,
                                     input int ew, input bit els,
                                     input bit bv, input int bt);
        bit ok = ref_ok();
        bit hit = 0;
        int hp = 0;
        if (rs) begin ref_reset(); return; end
        for (int i = 0; i < NHEAD; i++)
            if (h_live[i] && h_addr[i] == bt) begin hit = 1; hp = h_pos[i]; end
        if (bv) begin
            if (hit) begin m_mode = 1; m_rp = hp; m_want = bt; m_first = 1; end
            else     begin m_mode = 2; m_missq = bt; end
        end else if (ok) begin
            m_rp = (m_rp + 1) % DEPTH;
            m_want = (m_want + 1) & 16'hFFFF;
            m_first = 0;
        end else m_mode = 0;
        if (ev) begin
            int slot = -1;
            for (int i = 0; i < NHEAD; i++)
                if (h_live[i] && h_pos[i] == r_wp) h_live[i] = 0;
            if (els) begin
                for (int i = 0; i < NHEAD; i++)
                    if (slot < 0 && h_live[i] && h_addr[i] == ea) slot = i;
                for (int i = 0; i < NHEAD; i++)
                    if (slot < 0 && !h_live[i]) slot = i;
                if (slot < 0) begin slot = h_rr; h_rr = (h_rr + 1) % NHEAD; end
                h_live[slot] = 1; h_pos[slot] = r_wp; h_addr[slot] = ea;
            end
            r_addr[r_wp] = ea; r_word[r_wp] = ew; r_held[r_wp] = 1;
            r_wp = (r_wp + 1) % DEPTH;
        end
    endfunction

    task automatic step(input bit ev, input int ea, input bit els,
                        input bit bv, input int bt);
        int ew = (ea * 40503 + 32'h1357_0000) ^ 32'h00A5_5A00;
        @(negedge clk);
        compare();
        ex_valid = ev; ex_addr = 16'(ea); ex_word = ew;
        ex_loop_start = els; br_valid = bv; br_target = 16'(bt);
        ref_step(rst, ev, ea, ew, els, bv, bt);
    endtask

    task automatic exec(input int a, input bit ls);
        step(1'b1, a, ls, 1'b0, 0);
    endtask

    task automatic jump(input int t);
        step(1'b0, 0, 1'b0, 1'b1, t);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 0, 1'b0, 1'b0, 0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #1_500_000;
        bad++;
        $display("FAIL watchdog act=hung exp=finished");
        finish_run();
    end

    initial begin
        ref_reset();
        do_reset();

        // R1: quiet after reset
        tag = "R1";
        idle(3);

        // R11 + R10: no head yet, branch misses with target
        tag = "R11";
        exec(16'h0100, 1'b0);
        exec(16'h0101, 1'b0);
        jump(16'h0100);
        tag = "R10";
        idle(2);
        check("R11", "no replay before head", hits_seen, 0);

        // R3 / R4 / R7: loop head at 0x0110, eight words, replay then miss at 0x0118
        do_reset();
        tag = "R3";
        for (int i = 0; i < 8; i++) exec(16'h0110 + i, i == 0);
        tag = "R4";
        jump(16'h0110);
        tag = "R7";
        idle(10);
        check("R3", "words replayed", hits_seen, 8);

        // R12: branch mid-replay, writes arriving during replay
        tag = "R12";
        jump(16'h0110);
        idle(3);
        jump(16'h0110);
        step(1'b1, 16'h0118, 1'b0, 1'b0, 0);
        idle(3);
        jump(16'h0999);
        idle(2);

        // R5: nested heads in one run
        do_reset();
        tag = "R5";
        for (int i = 0; i < 16; i++)
            exec(16'h0200 + i, i == 0 || i == 4 || i == 9);
        jump(16'h0204);
        idle(14);
        jump(16'h0209);
        idle(8);
        jump(16'h0200);
        idle(18);

        // R8: address break in the record
        do_reset();
        tag = "R8";
        exec(16'h0300, 1'b1);
        exec(16'h0301, 1'b0);
        exec(16'h0302, 1'b0);
        exec(16'h0480, 1'b0);
        exec(16'h0481, 1'b0);
        jump(16'h0300);
        idle(5);

        // R9: round-robin replacement and in-place update
        do_reset();
        tag = "R9";
        exec(16'h0600, 1'b1);
        exec(16'h0610, 1'b1);
        exec(16'h0620, 1'b1);
        exec(16'h0630, 1'b1);
        exec(16'h0640, 1'b1);
        jump(16'h0600);
        idle(2);
        jump(16'h0610);
        idle(3);
        exec(16'h0650, 1'b1);
        jump(16'h0610);
        idle(2);
        exec(16'h0620, 1'b1);
        exec(16'h0621, 1'b0);
        jump(16'h0620);
        idle(4);
        jump(16'h0640);
        idle(3);

        // R2 / R6: run longer than the record, oldest entries replaced
        do_reset();
        tag = "R2";
        for (int i = 0; i < 40; i++)
            exec(16'h0500 + i, i == 3 || i == 10);
        tag = "R6";
        jump(16'h0503);
        idle(2);
        tag = "R2";
        jump(16'h050A);
        idle(34);
        tag = "R6";
        exec(16'h0528, 1'b0);
        exec(16'h0529, 1'b0);
        exec(16'h052A, 1'b0);
        jump(16'h050A);
        idle(3);

        // R10 / R12: mixed traffic
        tag = "R10";
        for (int k = 0; k < 60; k++) begin
            if (k % 7 == 0) jump(16'h0700 + (k % 3) * 8);
            else exec(16'h0700 + (k % 24), (k % 8) == 1);
        end
        idle(30);

        finish_run();
    end

endmodule